// File: doc/BRIEF.md
# Cycle-Synchronous Oversampled Output Serializer

This block drives one digital output pin from a 32-bit pattern that is played out once per application cycle. Each cycle is divided into 32 slots of equal length, and each slot shows one bit of the pattern. The pattern, the cycle length in clock ticks, and an output inversion flag are written through plain write-enable ports.

Playout starts only on a transfer-time sync pulse. The pattern is double-buffered. Host writes go to a staging register, and the sync pulse copies that register into the active shifter, so a write made during a cycle never disturbs the cycle in progress. The cycle period is also captured at the sync pulse.

A range check flags any period whose slot would be shorter than the minimum slot length. While the flag is set, sync pulses are ignored and the pin holds its level. Without sync pulses the pin never starts a playout.

Top module: `osdq_serializer`

## Requirements
- R1: After reset, `dout` is 0, inversion is off, the period register is 0, and `range_err` is 1.
- R2: A cycle is split into 32 slots that together last exactly P ticks, where P is the captured period. With q = P/32 and r = P mod 32, slot i lasts q+1 ticks when i < r and q ticks otherwise.
- R3: Bit 31 of the pattern is shown in the first slot and bit 0 in the last. The first slot begins in the clock cycle after the edge that samples `sync_in` high.
- R4: A write to the pattern port goes only to the staging register. The cycle in progress is unchanged. A write sampled on the same edge as an accepted sync is not loaded by that sync; it takes effect at the following sync.
- R5: If no pattern is written between two syncs, the second cycle repeats the same pattern.
- R6: After the 32nd slot, `dout` holds the level of bit 0 until the next accepted sync. A sync sampled on the edge that ends the last slot restarts the playout at once, with no gap.
- R7: Until the first accepted sync, `dout` stays at the reset level. Between syncs, the pin changes only at slot boundaries.
- R8: `dout` equals the pattern level XOR the inversion flag. A change to the flag is visible one cycle after its write, even while the pattern is held.
- R9: `range_err` is 1 exactly when floor(period/32) < MIN_SLOT. With the default MIN_SLOT of 2, period 64 passes and period 63 fails. While the flag is set, sync pulses are ignored and the pattern level freezes, including in the middle of a cycle.
- R10: The period is captured at the sync. A valid period written during a cycle changes the slot timing only from the next sync onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_pattern_en | input | 1 | Write strobe for the staging pattern |
| wr_pattern | input | SLOTS (32) | Next pattern, MSB shown first |
| wr_period_en | input | 1 | Write strobe for the period |
| wr_period | input | PERIOD_W (16) | Cycle length in clock ticks |
| wr_invert_en | input | 1 | Write strobe for the inversion flag |
| wr_invert | input | 1 | 1 inverts the pin level |
| sync_in | input | 1 | One-tick setpoint-transfer sync pulse |
| dout | output | 1 | Serialized output level |
| range_err | output | 1 | Period gives a slot shorter than MIN_SLOT |

## Verification
Two pairs of events can land on the same edge.

The first pair is a host pattern write and an accepted sync. The bench raises both strobes for the same tick at the end of a cycle. It then expects the old pattern for one full cycle and the new pattern in the cycle after that.

The second pair is the end of slot 31 and the next sync. The bench times the sync so that it is sampled exactly P edges after the previous one. It checks every tick of the next cycle against slot boundaries computed from q and r, so any lost or doubled tick at the seam shows up.

A period rewrite that makes the range check fail in the middle of a cycle is judged the same way. The bench expects the level to freeze from the tick after the write takes effect.

// File: rtl/osdq_pkg.sv
`timescale 1ns/1ps
package osdq_pkg;

   // playout state of the slot timer
   typedef enum logic [1:0] {
      PB_IDLE = 2'd0,   // no sync accepted yet
      PB_RUN  = 2'd1,   // slots being played
      PB_HOLD = 2'd2    // last slot done or halted, level held
   } pb_state_t;

endpackage

// File: rtl/osdq_cfg_regs.sv
`timescale 1ns/1ps
module osdq_cfg_regs #(
   parameter int SLOTS    = 32,
   parameter int PERIOD_W = 16,
   parameter int MIN_SLOT = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_pattern_en,
   input  logic [SLOTS-1:0]             wr_pattern,
   input  logic                         wr_period_en,
   input  logic [PERIOD_W-1:0]          wr_period,
   input  logic                         wr_invert_en,
   input  logic                         wr_invert,
   output logic [SLOTS-1:0]             staged_q,
   output logic                         invert_q,
   output logic [PERIOD_W-1:0]          cfg_q,
   output logic [$clog2(SLOTS)-1:0]     cfg_r,
   output logic                         range_err
);
   localparam int IDX_W = $clog2(SLOTS);
   localparam bit POW2  = ((SLOTS & (SLOTS - 1)) == 0);

   logic [PERIOD_W-1:0] period_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q <= '0;
         period_q <= '0;
         invert_q <= 1'b0;
      end else begin
         if (wr_pattern_en) staged_q <= wr_pattern;
         if (wr_period_en)  period_q <= wr_period;
         if (wr_invert_en)  invert_q <= wr_invert;
      end
   end

   // slot quotient and remainder: shift for power-of-two slot counts
   generate
      if (POW2) begin : g_pow2
         assign cfg_q = period_q >> IDX_W;
         assign cfg_r = period_q[IDX_W-1:0];
      end else begin : g_div
         assign cfg_q = period_q / PERIOD_W'(SLOTS);
         assign cfg_r = IDX_W'(period_q % PERIOD_W'(SLOTS));
      end
   endgenerate

   assign range_err = (cfg_q < PERIOD_W'(MIN_SLOT));

   // R4
   staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pattern_en |=> $stable(staged_q));

endmodule

// File: rtl/osdq_slot_timer.sv
`timescale 1ns/1ps
module osdq_slot_timer
   import osdq_pkg::*;
#(
   parameter int SLOTS    = 32,
   parameter int PERIOD_W = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic                         halt,
   input  logic [PERIOD_W-1:0]          cfg_q,
   input  logic [$clog2(SLOTS)-1:0]     cfg_r,
   output logic                         step
);
   localparam int                 IDX_W = $clog2(SLOTS);
   localparam logic [IDX_W-1:0]   LAST  = IDX_W'(SLOTS - 1);

   pb_state_t           st_q;
   logic [PERIOD_W-1:0] act_q;
   logic [IDX_W-1:0]    act_r;
   logic [PERIOD_W-1:0] tick_q;
   logic [IDX_W-1:0]    slot_q;
   logic                slot_end;

   function automatic logic [PERIOD_W-1:0] slot_len(
      input logic [IDX_W-1:0]    idx,
      input logic [PERIOD_W-1:0] q,
      input logic [IDX_W-1:0]    r);
      return q + PERIOD_W'(idx < r);
   endfunction

   assign slot_end = (st_q == PB_RUN) && (tick_q == '0) && !halt && !load;
   assign step     = slot_end && (slot_q != LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PB_IDLE;
         act_q  <= '0;
         act_r  <= '0;
         tick_q <= '0;
         slot_q <= '0;
      end else if (load) begin
         st_q   <= PB_RUN;
         act_q  <= cfg_q;
         act_r  <= cfg_r;
         slot_q <= '0;
         tick_q <= slot_len('0, cfg_q, cfg_r) - 1'b1;
      end else if (halt) begin
         if (st_q == PB_RUN) st_q <= PB_HOLD;
      end else if (st_q == PB_RUN) begin
         if (tick_q != '0) begin
            tick_q <= tick_q - 1'b1;
         end else if (slot_q == LAST) begin
            st_q <= PB_HOLD;
         end else begin
            slot_q <= slot_q + 1'b1;
            tick_q <= slot_len(slot_q + 1'b1, act_q, act_r) - 1'b1;
         end
      end
   end

   // R2
   last_slot_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && slot_q == LAST) |=> (st_q == PB_HOLD));

   // R6
   slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PB_RUN && !load) |=>
         (slot_q == $past(slot_q) || slot_q == $past(slot_q) + 1'b1));

   // R10
   period_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_q) && $stable(act_r)));

endmodule

// File: rtl/osdq_shifter.sv
`timescale 1ns/1ps
module osdq_shifter #(
   parameter int SLOTS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [SLOTS-1:0] staged,
   output logic             level
);
   logic [SLOTS-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh_q <= '0;
      else if (load) sh_q <= staged;
      else if (step) sh_q <= {sh_q[SLOTS-2:0], 1'b0};
   end

   assign level = sh_q[SLOTS-1];

   // R3
   first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (level == $past(staged[SLOTS-1])));

   // R7
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(level));

endmodule

// File: rtl/osdq_serializer.sv
`timescale 1ns/1ps
module osdq_serializer #(
   parameter int SLOTS    = 32,
   parameter int PERIOD_W = 16,
   parameter int MIN_SLOT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_pattern_en,
   input  logic [SLOTS-1:0]    wr_pattern,
   input  logic                wr_period_en,
   input  logic [PERIOD_W-1:0] wr_period,
   input  logic                wr_invert_en,
   input  logic                wr_invert,
   input  logic                sync_in,
   output logic                dout,
   output logic                range_err
);
   localparam int IDX_W = $clog2(SLOTS);

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("SLOTS must be at least 2");
      end
      if (MIN_SLOT < 1) begin : g_bad_min
         $error("MIN_SLOT must be at least 1");
      end
      if (PERIOD_W <= IDX_W) begin : g_bad_pw
         $error("PERIOD_W must exceed log2(SLOTS)");
      end
   endgenerate

   logic [SLOTS-1:0]    staged;
   logic                invert_q;
   logic [PERIOD_W-1:0] cfg_q;
   logic [IDX_W-1:0]    cfg_r;
   logic                load;
   logic                step;
   logic                level;

   osdq_cfg_regs #(.SLOTS(SLOTS), .PERIOD_W(PERIOD_W), .MIN_SLOT(MIN_SLOT)) cfg_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_pattern_en (wr_pattern_en),
      .wr_pattern    (wr_pattern),
      .wr_period_en  (wr_period_en),
      .wr_period     (wr_period),
      .wr_invert_en  (wr_invert_en),
      .wr_invert     (wr_invert),
      .staged_q      (staged),
      .invert_q      (invert_q),
      .cfg_q         (cfg_q),
      .cfg_r         (cfg_r),
      .range_err     (range_err)
   );

   assign load = sync_in && !range_err;

   osdq_slot_timer #(.SLOTS(SLOTS), .PERIOD_W(PERIOD_W)) tmr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .halt  (range_err),
      .cfg_q (cfg_q),
      .cfg_r (cfg_r),
      .step  (step)
   );

   osdq_shifter #(.SLOTS(SLOTS)) sh_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .staged (staged),
      .level  (level)
   );

   assign dout = level ^ invert_q;

   // R9
   range_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |=> $stable(level));

   // R8
   invert_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step && wr_invert_en && (wr_invert != invert_q)) |=> (dout != $past(dout)));

endmodule

// File: tb/osdq_serializer_tb.sv
`timescale 1ns/1ps
module osdq_serializer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_pattern_en = 1'b0;
   logic [31:0] wr_pattern = '0;
   logic        wr_period_en = 1'b0;
   logic [15:0] wr_period = '0;
   logic        wr_invert_en = 1'b0;
   logic        wr_invert = 1'b0;
   logic        sync_in = 1'b0;
   logic        dout;
   logic        range_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   osdq_serializer #(.SLOTS(32), .PERIOD_W(16), .MIN_SLOT(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_pattern_en(wr_pattern_en), .wr_pattern(wr_pattern),
      .wr_period_en(wr_period_en), .wr_period(wr_period),
      .wr_invert_en(wr_invert_en), .wr_invert(wr_invert),
      .sync_in(sync_in), .dout(dout), .range_err(range_err));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int slot_of(input int k, input int per);
      int q = per / 32;
      int r = per % 32;
      if (k >= per) return 31;
      if (k < r * (q + 1)) return k / (q + 1);
      return r + (k - r * (q + 1)) / q;
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr_pat(input logic [31:0] v);
      wr_pattern = v; wr_pattern_en = 1'b1; tick(); wr_pattern_en = 1'b0;
   endtask

   task automatic wr_per(input int v);
      wr_period = 16'(v); wr_period_en = 1'b1; tick(); wr_period_en = 1'b0;
   endtask

   task automatic wr_inv(input logic v);
      wr_invert = v; wr_invert_en = 1'b1; tick(); wr_invert_en = 1'b0;
   endtask

   task automatic kick();
      sync_in = 1'b1; tick(); sync_in = 1'b0;
   endtask

   // Called with the sync just sampled; checks n ticks of one cycle.
   task automatic play(input logic [31:0] pat, input int per, input logic inv, input int n,
                       input int mid_k, input bit mid_wr, input logic [31:0] mid_pat,
                       input bit mid_pw, input int mid_per,
                       input bit sync_end, input bit wr_sync, input logic [31:0] sync_pat,
                       input string tag);
      int halt_k = -1;
      for (int k = 0; k < n; k++) begin
         if (k > 0) tick();
         wr_pattern_en = 1'b0; wr_period_en = 1'b0; sync_in = 1'b0;
         begin
            int kk = (halt_k >= 0 && k > halt_k) ? halt_k : k;
            logic e = pat[31 - slot_of(kk, per)] ^ inv;
            chk(dout === e, tag, int'(dout), int'(e));
         end
         if (k == mid_k && mid_wr) begin
            wr_pattern = mid_pat; wr_pattern_en = 1'b1;
         end
         if (k == mid_k && mid_pw) begin
            wr_period = 16'(mid_per); wr_period_en = 1'b1;
            if (mid_per / 32 < 2) halt_k = k + 1;
         end
         if (k == n - 1 && sync_end) sync_in = 1'b1;
         if (k == n - 1 && wr_sync) begin
            wr_pattern = sync_pat; wr_pattern_en = 1'b1;
         end
      end
      tick();
      wr_pattern_en = 1'b0; wr_period_en = 1'b0; sync_in = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] pats [5];
      int pers [7];
      logic [31:0] p1, p2, p3, p4, p5;
      logic held;
      pats = '{32'hA5A5_F00F, 32'hAAAA_AAAA, 32'h8000_0001, 32'h7FFF_FFFE, 32'h0};
      pers = '{64, 65, 77, 95, 96, 127, 200};

      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(dout === 1'b0, "R1 dout", int'(dout), 0);
      chk(range_err === 1'b1, "R1 range_err", int'(range_err), 1);

      // R9: sync ignored with period 0; R7: no playout
      kick();
      for (int i = 0; i < 8; i++) begin
         chk(dout === 1'b0, "R9 sync ignored", int'(dout), 0);
         tick();
      end

      wr_pat(32'hFFFF_FFFF);
      wr_per(64);
      chk(range_err === 1'b0, "R9 period 64 accepted", int'(range_err), 0);
      // R7: configured but no sync -> no playout
      for (int i = 0; i < 40; i++) begin
         chk(dout === 1'b0, "R7 no sync", int'(dout), 0);
         tick();
      end
      wr_per(63);
      chk(range_err === 1'b1, "R9 period 63 rejected", int'(range_err), 1);

      // R2/R3/R6 sweep over periods and patterns
      for (int pi = 0; pi < 5; pi++) begin
         for (int qi = 0; qi < 7; qi++) begin
            logic [31:0] p = (pi == 4) ? 32'(qi + 1) * 32'h9E37_79B9 : pats[pi];
            wr_pat(p);
            wr_per(pers[qi]);
            kick();
            play(p, pers[qi], 1'b0, pers[qi] + 4, -1, 0, '0, 0, 0, 0, 0, '0, "R2 R3 R6 sweep");
         end
      end

      // R6 back-to-back seam; R4 write coinciding with sync; R5 repeat
      p1 = 32'hC3A5_5A3C; p2 = 32'h1248_8421;
      wr_pat(p1); wr_per(70); kick();
      play(p1, 70, 1'b0, 70, -1, 0, '0, 0, 0, 1, 1, p2, "R6 seam");
      play(p1, 70, 1'b0, 70, -1, 0, '0, 0, 0, 1, 0, '0, "R4 coincident write");
      play(p2, 70, 1'b0, 70, -1, 0, '0, 0, 0, 1, 0, '0, "R4 staged next");
      play(p2, 70, 1'b0, 74, -1, 0, '0, 0, 0, 0, 0, '0, "R5 repeat");

      // R4 mid-cycle write not visible until next sync
      p3 = 32'hF0F0_0F0F; p4 = 32'h9669_6996;
      wr_pat(p3); kick();
      play(p3, 70, 1'b0, 70, 20, 1, p4, 0, 0, 1, 0, '0, "R4 mid write");
      play(p4, 70, 1'b0, 74, -1, 0, '0, 0, 0, 0, 0, '0, "R4 after sync");

      // R10 period captured at sync
      wr_per(64); kick();
      play(p4, 64, 1'b0, 64, 10, 0, '0, 1, 96, 1, 0, '0, "R10 old period kept");
      play(p4, 96, 1'b0, 100, -1, 0, '0, 0, 0, 0, 0, '0, "R10 new period");

      // R8 inversion
      wr_inv(1'b1); kick();
      play(p4, 96, 1'b1, 100, -1, 0, '0, 0, 0, 0, 0, '0, "R8 inverted");
      wr_inv(1'b0);
      chk(dout === p4[0], "R8 invert off while held", int'(dout), int'(p4[0]));

      // R9 range error in mid-cycle freezes level, later syncs ignored
      kick();
      play(p4, 96, 1'b0, 90, 30, 0, '0, 1, 50, 0, 0, '0, "R9 mid halt");
      chk(range_err === 1'b1, "R9 flag after bad period", int'(range_err), 1);
      held = p4[31 - slot_of(31, 96)];
      p5 = 32'h0FF0_F00F;
      wr_pat(p5); kick();
      for (int i = 0; i < 10; i++) begin
         chk(dout === held, "R9 sync ignored while flagged", int'(dout), int'(held));
         tick();
      end
      wr_per(64);
      chk(range_err === 1'b0, "R9 flag cleared", int'(range_err), 0);
      kick();
      play(p5, 64, 1'b0, 68, -1, 0, '0, 0, 0, 0, 0, '0, "R9 recovery");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule